// File: doc/BRIEF.md
# Bus-Controlled Interrupt Request Combiner

This block sits on an 8-bit CPU bus and gathers interrupt events from five peripheral sources into one shared active-low request line. Each source keeps an enable state and a pending flag. Software changes them with writes and reads at fixed bus addresses, and each source follows its own rule for how it is turned on, turned off and acknowledged. Some sources are acknowledged by a read side effect. Others can only be acknowledged by turning them off and on again. Some are turned on only by one exact data value or bit pattern.

The request line goes low whenever at least one enabled source holds a pending event. The CPU looks at the line only between instructions, so a pending flag stays set until it is explicitly cleared. A status read returns the pending flags of the two sources that share the status address.

Each source is a three-state machine. The states are `SRC_OFF` (disabled, nothing pending), `SRC_ARMED` (enabled, nothing pending) and `SRC_PEND` (enabled, event pending). The transitions are:

- **enable**: `SRC_OFF` to `SRC_ARMED`.
- **disable**: `SRC_ARMED` or `SRC_PEND` to `SRC_OFF`.
- **fire**: `SRC_ARMED` to `SRC_PEND`, on an event pulse.
- **acknowledge**: `SRC_PEND` to `SRC_ARMED`, only when no event arrives in the same cycle.
- **hold**: the state stays as it is in every other case.

Top module: `irq_agg_top`

## Requirements
- R1: After reset, all sources are disabled, no flag is pending, `irq_n` is 1, and a status read at 0x4015 returns 0x00.
- R2: `irq_n` is 0 exactly when at least one source is pending, and 1 otherwise.
- R3: An event pulse on `src_evt` sets a source's pending flag only if that source was already enabled before that cycle. An event on a disabled source is lost. Event bit mapping: bit0 is playback-finish, bit1 is frame-sequencer, bit2 is counter-mapper, bit3 is extended-mapper, bit4 is disk-interface.
- R4: A disable command clears that source's pending flag and enable state. A disable wins over an event pulse that arrives in the same cycle.
- R5: Playback-finish source:
  - A write to 0x4010 with data bit 7 = 1 enables it.
  - A write to 0x4010 with bit 7 = 0 disables it.
  - It is acknowledged by a `smp_restart` pulse, or by disabling and then re-enabling it.
- R6: Frame-sequencer source:
  - A write to 0x4017 with data bits 7:6 = 00 enables it.
  - Any other value written to 0x4017 disables it.
  - A read of 0x4015 acknowledges it.
- R7: Counter-mapper source:
  - Any write to 0xE001 enables it.
  - Any write to 0xE000 disables it.
  - Repeating the enable write while it is pending leaves it pending.
  - No read acknowledges it.
- R8: Extended-mapper source:
  - Writing 0x80 to 0x5204 enables it.
  - Writing 0x00 to 0x5204 disables it.
  - Any other value written to 0x5204 has no effect.
  - A read of 0x5204 acknowledges it.
- R9: Disk-interface source:
  - Writing 0x02 to 0x4022 enables it.
  - Writing 0x00 to 0x4022 disables it.
  - Any other value written to 0x4022 has no effect.
  - A read of 0x4030 acknowledges it.
- R10: A pending flag stays set over any number of cycles until that source's own acknowledge or disable occurs.
- R11: If an acknowledge and a new event for the same source fall in the same cycle, the flag stays pending.
- R12: A read at 0x4015 returns, in the same cycle:
  - bit 7 = playback-finish pending;
  - bit 6 = frame-sequencer pending;
  - bits 5:0 = 0.

  Every other read, and every cycle without a read, returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| src_evt | input | 5 | Event pulses, one bit per source |
| smp_restart | input | 1 | Pulse when a new sample starts playing (acknowledges the playback-finish source) |
| irq_n | output | 1 | Active-low shared interrupt request |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |

## Verification
The two functions that can collide are the acknowledge side effect of a read and a new event pulse for the same source. If both land in the same clock edge and the event is dropped, an interrupt is lost.

The bench provokes this collision in two ways:
- In a directed step, it reads 0x4015 while pulsing the frame-sequencer event.
- In a long random phase, it produces the collision repeatedly for the 0x4015, 0x5204 and 0x4030 acknowledges, and for the `smp_restart` acknowledge of the playback source.

A behavioural model updates its flags with the rule "event beats acknowledge, disable beats both". Every cycle, the bench compares `irq_n` and `bus_rdata` with that model, so a lost flag shows up either on the request line or in the next status read.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Number of sources. Index order is also the src_evt bit order.
    localparam int NSRC      = 5;
    localparam int SRC_PLAY  = 0;
    localparam int SRC_FRAME = 1;
    localparam int SRC_CNT   = 2;
    localparam int SRC_EXT   = 3;
    localparam int SRC_DISK  = 4;

    // Bus addresses, fixed by the software contract.
    localparam logic [15:0] A_PLAY_CTL  = 16'h4010;
    localparam logic [15:0] A_STATUS    = 16'h4015;
    localparam logic [15:0] A_FRAME_CTL = 16'h4017;
    localparam logic [15:0] A_DISK_CTL  = 16'h4022;
    localparam logic [15:0] A_DISK_STAT = 16'h4030;
    localparam logic [15:0] A_EXT_CTL   = 16'h5204;
    localparam logic [15:0] A_CNT_OFF   = 16'hE000;
    localparam logic [15:0] A_CNT_ON    = 16'hE001;

    // Exact-match data codes.
    localparam logic [7:0] EXT_ON   = 8'h80;
    localparam logic [7:0] DISK_ON  = 8'h02;
    localparam logic [7:0] CODE_OFF = 8'h00;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_ARMED = 2'd1,
        SRC_PEND  = 2'd2
    } src_state_e;

    // One command bundle per source, produced by the decoder each cycle.
    typedef struct packed {
        logic en;
        logic dis;
        logic ack;
    } src_cmd_t;

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic                      smp_restart,
    output src_cmd_t [NSRC-1:0]       cmd
);

    localparam int TOP_BIT = DATA_W - 1;

    // One-hot address hits, shared by all sources.
    logic hit_play, hit_stat, hit_frame, hit_dctl, hit_dstat;
    logic hit_ext, hit_coff, hit_con;

    always_comb begin
        hit_play  = (bus_addr == ADDR_W'(A_PLAY_CTL));
        hit_stat  = (bus_addr == ADDR_W'(A_STATUS));
        hit_frame = (bus_addr == ADDR_W'(A_FRAME_CTL));
        hit_dctl  = (bus_addr == ADDR_W'(A_DISK_CTL));
        hit_dstat = (bus_addr == ADDR_W'(A_DISK_STAT));
        hit_ext   = (bus_addr == ADDR_W'(A_EXT_CTL));
        hit_coff  = (bus_addr == ADDR_W'(A_CNT_OFF));
        hit_con   = (bus_addr == ADDR_W'(A_CNT_ON));
    end

    // Each source picks its own rule.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == SRC_PLAY) begin : g_play
            // Top data bit selects on/off; a new sample acknowledges.
            assign cmd[i].en  = bus_wr & hit_play &  bus_wdata[TOP_BIT];
            assign cmd[i].dis = bus_wr & hit_play & ~bus_wdata[TOP_BIT];
            assign cmd[i].ack = smp_restart;
        end else if (i == SRC_FRAME) begin : g_frame
            // Top two data bits both zero enables; anything else disables.
            logic pat_zero;
            assign pat_zero   = (bus_wdata[TOP_BIT -: 2] == 2'b00);
            assign cmd[i].en  = bus_wr & hit_frame &  pat_zero;
            assign cmd[i].dis = bus_wr & hit_frame & ~pat_zero;
            assign cmd[i].ack = bus_rd & hit_stat;
        end else if (i == SRC_CNT) begin : g_cnt
            // Address alone decides; no read acknowledge.
            assign cmd[i].en  = bus_wr & hit_con;
            assign cmd[i].dis = bus_wr & hit_coff;
            assign cmd[i].ack = 1'b0;
        end else if (i == SRC_EXT) begin : g_ext
            // Exact data codes; other values ignored.
            assign cmd[i].en  = bus_wr & hit_ext & (bus_wdata == DATA_W'(EXT_ON));
            assign cmd[i].dis = bus_wr & hit_ext & (bus_wdata == DATA_W'(CODE_OFF));
            assign cmd[i].ack = bus_rd & hit_ext;
        end else begin : g_disk
            // Exact data codes; acknowledge sits at a separate address.
            assign cmd[i].en  = bus_wr & hit_dctl & (bus_wdata == DATA_W'(DISK_ON));
            assign cmd[i].dis = bus_wr & hit_dctl & (bus_wdata == DATA_W'(CODE_OFF));
            assign cmd[i].ack = bus_rd & hit_dstat;
        end
    end

endmodule

// File: rtl/irq_src_fsm.sv
module irq_src_fsm
    import irq_agg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_cmd_t cmd,
    input  logic     evt,
    output logic     pending
);

    src_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRC_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state. Priority: disable, then event, then acknowledge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_OFF: begin
                if (cmd.en && !cmd.dis) begin
                    state_d = SRC_ARMED;    // enable
                end
            end
            SRC_ARMED: begin
                if (cmd.dis) begin
                    state_d = SRC_OFF;      // disable
                end else if (evt) begin
                    state_d = SRC_PEND;     // fire
                end
            end
            SRC_PEND: begin
                if (cmd.dis) begin
                    state_d = SRC_OFF;      // disable
                end else if (cmd.ack && !evt) begin
                    state_d = SRC_ARMED;    // acknowledge
                end
            end
            default: state_d = SRC_OFF;
        endcase
    end

    // Output decode.
    always_comb begin
        pending = (state_q == SRC_PEND);
    end

    // R4
    dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd.dis) |-> !pending);

    // R3
    off_evt_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == SRC_OFF) |-> !pending);

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pending) && !$past(cmd.ack) && !$past(cmd.dis)) |-> pending);

    // R11
    ack_evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pending) && $past(evt) && !$past(cmd.dis)) |-> pending);

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NSRC-1:0]   src_evt,
    input  logic              smp_restart,
    output logic              irq_n,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int BIT_PLAY  = DATA_W - 1;
    localparam int BIT_FRAME = DATA_W - 2;

    src_cmd_t [NSRC-1:0] cmd;
    logic     [NSRC-1:0] pend;

    irq_cmd_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .smp_restart (smp_restart),
        .cmd         (cmd)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_fsm
        irq_src_fsm u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd[i]),
            .evt     (src_evt[i]),
            .pending (pend[i])
        );
    end

    // Wired-OR request line, active low.
    always_comb begin
        irq_n = ~(|pend);
    end

    // Status read data, combinational during the read strobe.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && (bus_addr == ADDR_W'(A_STATUS))) begin
            bus_rdata[BIT_PLAY]  = pend[SRC_PLAY];
            bus_rdata[BIT_FRAME] = pend[SRC_FRAME];
        end
    end

    // R12
    stat_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(A_STATUS)) |-> (bus_rdata[DATA_W-3:0] == '0));

    // R12
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

    // R3
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(|src_evt));

endmodule

// File: tb/test_irq_agg_top.sv
module test_irq_agg_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [4:0]  src_evt;
    logic        smp_restart;
    logic        irq_n;
    logic [7:0]  bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int n_cyc = 0;
    bit done  = 0;

    // Reference state: bit s = source s (0 play, 1 frame, 2 counter, 3 ext, 4 disk).
    bit m_en   [5];
    bit m_pend [5];

    always #2 clk = ~clk;   // 250 MHz

    irq_agg_top i_irq_agg_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .src_evt     (src_evt),
        .smp_restart (smp_restart),
        .irq_n       (irq_n),
        .bus_rdata   (bus_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at cycle %0d", tag, act, exp, n_cyc);
        end
    endtask

    // Advance the model by one clock edge, using the inputs held this cycle.
    function automatic void model_step();
        bit on [5], off [5], ack [5];
        on[0]  = bus_wr && bus_addr == 16'h4010 &&  bus_wdata[7];
        off[0] = bus_wr && bus_addr == 16'h4010 && !bus_wdata[7];
        ack[0] = smp_restart;
        on[1]  = bus_wr && bus_addr == 16'h4017 && bus_wdata[7:6] == 2'b00;
        off[1] = bus_wr && bus_addr == 16'h4017 && bus_wdata[7:6] != 2'b00;
        ack[1] = bus_rd && bus_addr == 16'h4015;
        on[2]  = bus_wr && bus_addr == 16'hE001;
        off[2] = bus_wr && bus_addr == 16'hE000;
        ack[2] = 0;
        on[3]  = bus_wr && bus_addr == 16'h5204 && bus_wdata == 8'h80;
        off[3] = bus_wr && bus_addr == 16'h5204 && bus_wdata == 8'h00;
        ack[3] = bus_rd && bus_addr == 16'h5204;
        on[4]  = bus_wr && bus_addr == 16'h4022 && bus_wdata == 8'h02;
        off[4] = bus_wr && bus_addr == 16'h4022 && bus_wdata == 8'h00;
        ack[4] = bus_rd && bus_addr == 16'h4030;
        for (int s = 0; s < 5; s++) begin
            if (off[s]) begin
                m_en[s] = 0;
                m_pend[s] = 0;
            end else if (!m_en[s]) begin
                m_en[s] = on[s];
            end else if (src_evt[s]) begin
                m_pend[s] = 1;
            end else if (ack[s]) begin
                m_pend[s] = 0;
            end
        end
    endfunction

    // One bus cycle: drive at the falling edge, check mid-cycle, update the model at the rising edge.
    task automatic cyc(input string tag, input logic [15:0] a, input logic [7:0] d,
                       input logic w, input logic r, input logic [4:0] e, input logic st);
        logic [7:0] exp_rd;
        int any;
        bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r; src_evt = e; smp_restart = st;
        #1;
        any = 0;
        for (int s = 0; s < 5; s++) any += m_pend[s];
        exp_rd = (r && a == 16'h4015) ? {m_pend[0], m_pend[1], 6'b0} : 8'h00;
        check({tag, " irq_n"}, {7'b0, irq_n}, {7'b0, (any == 0)});
        check({tag, " rdata"}, bus_rdata, exp_rd);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic wr(input string tag, input logic [15:0] a, input logic [7:0] d);
        cyc(tag, a, d, 1, 0, 5'b0, 0);
    endtask
    task automatic rd(input string tag, input logic [15:0] a);
        cyc(tag, a, 8'h00, 0, 1, 5'b0, 0);
    endtask
    task automatic ev(input string tag, input logic [4:0] e);
        cyc(tag, 16'h0000, 8'h00, 0, 0, e, 0);
    endtask
    task automatic idle(input string tag, input int n);
        for (int k = 0; k < n; k++) cyc(tag, 16'h0000, 8'h00, 0, 0, 5'b0, 0);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000 && !done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] alist [9];
        alist = '{16'h4010, 16'h4015, 16'h4017, 16'h4022, 16'h4030,
                  16'h5204, 16'hE000, 16'hE001, 16'h1234};
        for (int s = 0; s < 5; s++) begin m_en[s] = 0; m_pend[s] = 0; end
        rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_wr = 0; bus_rd = 0; src_evt = 0; smp_restart = 0;
        repeat (3) @(negedge clk);
        #1 check("R1 reset irq_n", {7'b0, irq_n}, 8'h01);
        @(negedge clk);
        rst_n = 1;
        rd("R1 status after reset", 16'h4015);

        ev("R3 events while disabled", 5'h1F);
        idle("R3 events lost", 2);

        // Playback-finish source.
        wr("R5 enable play", 16'h4010, 8'h80);
        ev("R5 play event", 5'h01);
        idle("R10 play held", 3);
        rd("R12 status play bit", 16'h4015);
        cyc("R5 restart ack", 16'h0000, 8'h00, 0, 0, 5'b0, 1);
        ev("R5 play event again", 5'h01);
        wr("R5 disable play", 16'h4010, 8'h7F);
        wr("R5 re-enable play", 16'h4010, 8'hFF);
        cyc("R11 restart with event", 16'h0000, 8'h00, 0, 0, 5'h01, 1);
        wr("R4 disable with event", 16'h4010, 8'h00);
        idle("R4 after disable", 1);

        // Frame-sequencer source.
        wr("R6 enable frame", 16'h4017, 8'h3F);
        ev("R6 frame event", 5'h02);
        rd("R6 status ack", 16'h4015);
        rd("R6 status after ack", 16'h4015);
        ev("R6 frame event 2", 5'h02);
        cyc("R11 read ack with event", 16'h4015, 8'h00, 0, 1, 5'h02, 0);
        rd("R11 still pending", 16'h4015);
        cyc("R4 disable wins", 16'h4017, 8'hC0, 1, 0, 5'h02, 0);
        rd("R4 frame cleared", 16'h4015);
        wr("R6 enable frame again", 16'h4017, 8'h00);
        wr("R6 pattern 40 disables", 16'h4017, 8'h40);
        ev("R6 event while off", 5'h02);

        // Counter-mapper source.
        wr("R7 enable counter", 16'hE001, 8'h00);
        ev("R7 counter event", 5'h04);
        rd("R7 no read ack 4015", 16'h4015);
        rd("R7 no read ack 5204", 16'h5204);
        rd("R7 no read ack 4030", 16'h4030);
        wr("R7 enable again keeps", 16'hE001, 8'h5A);
        idle("R7 held", 2);
        wr("R7 disable counter", 16'hE000, 8'hFF);
        wr("R7 re-enable counter", 16'hE001, 8'h00);
        wr("R7 disable counter end", 16'hE000, 8'h00);

        // Extended-mapper source.
        wr("R8 enable ext", 16'h5204, 8'h80);
        ev("R8 ext event", 5'h08);
        wr("R8 other value ignored", 16'h5204, 8'h55);
        rd("R8 read ack", 16'h5204);
        wr("R8 disable ext", 16'h5204, 8'h00);
        ev("R8 event while off", 5'h08);
        wr("R8 value 81 ignored", 16'h5204, 8'h81);
        ev("R8 still off", 5'h08);

        // Disk-interface source.
        wr("R9 enable disk", 16'h4022, 8'h02);
        ev("R9 disk event", 5'h10);
        wr("R9 other value ignored", 16'h4022, 8'h07);
        rd("R9 wrong read no ack", 16'h4015);
        rd("R9 read ack", 16'h4030);
        ev("R9 disk event 2", 5'h10);
        wr("R9 disable disk", 16'h4022, 8'h00);
        idle("R2 all clear", 2);

        // Random mixed traffic, collisions included.
        for (int k = 0; k < 4000; k++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int op;
            a  = alist[$urandom_range(0, 8)];
            op = $urandom_range(0, 3);
            case ($urandom_range(0, 4))
                0: d = 8'h80;
                1: d = 8'h00;
                2: d = 8'h02;
                default: d = 8'($urandom);
            endcase
            cyc("R2 random", a, d, op == 0, op == 1, 5'($urandom) & 5'($urandom),
                ($urandom_range(0, 7) == 0));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule